// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block steers the two ALU operand multiplexers of a five-stage in-order pipeline. For each of the two source registers of the instruction entering execute, it decides where the operand comes from. The choices are the register file, the ALU result held in the latch after the memory stage (the producer one instruction ahead), or the value being written back (the producer two instructions ahead, either an ALU result or load data). A producer three or more instructions ahead needs no bypass, because the register file writes in the first half of a cycle and reads in the second.

The comparison is done one cycle early. In the decode cycle the consumer's source specifiers are compared against the destination of the instruction now in execute (the near producer) and the instruction now in memory (the far producer). The result is registered, so the select codes are stable for the whole execute cycle and no comparator sits in front of the ALU. A near producer that is a load has no value in the memory-stage latch, so it is never chosen. The separate stall logic holds such a consumer back for one cycle, after which the load is the far producer.

Top module: `fwd_sel_unit`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both select codes are 00 (register file).
- R2: If the near producer writes a register, is not a load, and its nonzero destination equals a source, the select for that source is 10 (memory-stage ALU result).
- R3: If the far producer writes a register and its nonzero destination equals a source, and R2 does not apply, the select for that source is 01 (writeback value).
- R4: When both the near and the far producer qualify for the same source, the near one wins and the code is 10.
- R5: A destination of register 0 never forwards. A source of 0 always gets 00.
- R6: A producer whose write enable is low never forwards, whatever its destination.
- R7: A near producer flagged as a load never yields 10. The select falls through to the far producer (01) or to the register file (00).
- R8: With no qualifying producer, the select is 00.
- R9: The two operands are decided independently. Each select depends only on its own source.
- R10: The select codes are registered. Inputs presented in one cycle appear on the outputs after the next rising clock edge and not before.
- R11: Code 11 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | REG_AW | First source register of the decoding instruction |
| src_b | input | REG_AW | Second source register of the decoding instruction |
| near_dst | input | REG_AW | Destination of the instruction now in execute |
| near_wen | input | 1 | Near producer writes a register |
| near_load | input | 1 | Near producer's result comes from memory |
| far_dst | input | REG_AW | Destination of the instruction now in memory |
| far_wen | input | 1 | Far producer writes a register |
| sel_a | output | 2 | Select for operand A: 00 register file, 10 memory-stage ALU result, 01 writeback value |
| sel_b | output | 2 | Select for operand B, same encoding |

## Verification
The hardest situations to reach are those where several conditions overlap. Examples are a near load hiding behind a far match of the same register, a register-0 destination with write enable high, and both producers naming the same register while only one source matches. Ordinary instruction streams rarely line these up. The bench therefore shrinks the register specifier to three bits and sweeps every combination of both sources, both destinations and the three producer flags. That is 32768 input patterns, each checked one edge later against codes computed arithmetically from the requirements.

// File: rtl/fwd_sel_pkg.sv
package fwd_sel_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel_a;
        fwd_sel_e sel_b;
    } fwd_state_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wen,
    input  logic              usable,
    output logic              hit
);
    logic dst_live;

    always_comb begin
        dst_live = wen && usable && (dst != '0);
        hit      = dst_live && (dst == src);
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_sel_pkg::*;
(
    input  logic     near_hit,
    input  logic     far_hit,
    output fwd_sel_e sel
);
    always_comb begin
        if (near_hit)
            sel = SEL_MEM;
        else if (far_hit)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end
endmodule

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
    import fwd_sel_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [REG_AW-1:0] near_dst,
    input  logic              near_wen,
    input  logic              near_load,
    input  logic [REG_AW-1:0] far_dst,
    input  logic              far_wen,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_arr [NUM_OPS];
    logic              near_hit [NUM_OPS];
    logic              far_hit  [NUM_OPS];
    fwd_sel_e          sel_nxt  [NUM_OPS];

    fwd_state_t st_d, st_q;
    logic       past_ok_d, past_ok_q;

    assign src_arr[0] = src_a;
    assign src_arr[1] = src_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_match #(.REG_AW(REG_AW)) u_near (
            .src    (src_arr[g]),
            .dst    (near_dst),
            .wen    (near_wen),
            .usable (!near_load),
            .hit    (near_hit[g])
        );
        fwd_match #(.REG_AW(REG_AW)) u_far (
            .src    (src_arr[g]),
            .dst    (far_dst),
            .wen    (far_wen),
            .usable (1'b1),
            .hit    (far_hit[g])
        );
        fwd_pick u_pick (
            .near_hit (near_hit[g]),
            .far_hit  (far_hit[g]),
            .sel      (sel_nxt[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.sel_a = sel_nxt[0];
        st_d.sel_b = sel_nxt[1];
        past_ok_d  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '{sel_a: SEL_RF, sel_b: SEL_RF};
            past_ok_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            past_ok_q <= past_ok_d;
        end
    end

    assign sel_a = st_q.sel_a;
    assign sel_b = st_q.sel_b;

    AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11)); // R11

    AST_RESET_RF: assert property (@(posedge clk) disable iff (!rst_n)
        !past_ok_q |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R1

    AST_NEAR_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(near_wen && !near_load && near_dst != '0 && near_dst == src_a))
        |-> sel_a == 2'b10); // R2

    AST_FAR_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(far_wen && far_dst != '0 && far_dst == src_b)
                   && !$past(near_wen && !near_load && near_dst == src_b))
        |-> sel_b == 2'b01); // R3

    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(src_a == '0)) |-> sel_a == 2'b00); // R5

    AST_LOAD_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(near_load && (far_dst != near_dst || !far_wen)))
        |-> (sel_a != 2'b10 || $past(near_dst != src_a))); // R7

    AST_NO_WEN_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(!near_wen && !far_wen)) |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R6
endmodule

// File: tb/tb_fwd_sel_unit.sv
module tb_fwd_sel_unit;
    localparam int AW = 3;
    localparam int NR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] src_a = '0, src_b = '0, near_dst = '0, far_dst = '0;
    logic          near_wen = 1'b0, near_load = 1'b0, far_wen = 1'b0;
    logic [1:0]    sel_a, sel_b;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fwd_sel_unit #(.REG_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .near_dst(near_dst), .near_wen(near_wen), .near_load(near_load),
        .far_dst(far_dst), .far_wen(far_wen), .sel_a(sel_a), .sel_b(sel_b)
    );

    function automatic logic [1:0] model(input int s, input int nd, input int nw,
                                         input int nl, input int fd, input int fw);
        if (nw != 0 && nl == 0 && nd != 0 && nd == s) return 2'b10;
        if (fw != 0 && fd != 0 && fd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag(input int s, input int nd, input int nw,
                                  input int nl, input int fd, input int fw);
        logic [1:0] e;
        e = model(s, nd, nw, nl, fd, fw);
        if (e == 2'b10) return (fw != 0 && fd == s) ? "R4" : "R2";
        if (e == 2'b01) return (nd == s && nw != 0 && nl != 0) ? "R7" : "R3";
        if (s == 0) return "R5";
        if ((nd == s && nw == 0) || (fd == s && fw == 0)) return "R6";
        if (nd == s && nl != 0) return "R7";
        return "R8";
    endfunction

    task automatic check(input string r, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", r, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: matching inputs held during reset must not leak out
        src_a = 3'd2; src_b = 3'd3; near_dst = 3'd2; near_wen = 1'b1;
        far_dst = 3'd3; far_wen = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", sel_b, 2'b00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", sel_a, 2'b10);
        check("R1", sel_b, 2'b01);

        // R10: change inputs mid-cycle, output holds until the edge
        @(negedge clk);
        near_dst = 3'd5; far_dst = 3'd6;
        #1;
        check("R10", sel_a, 2'b10);
        check("R10", sel_b, 2'b01);
        @(negedge clk);
        check("R10", sel_a, 2'b00);
        check("R10", sel_b, 2'b00);

        // R4 directed: both producers name the same register
        near_dst = 3'd4; far_dst = 3'd4; src_a = 3'd4; src_b = 3'd1;
        near_wen = 1'b1; near_load = 1'b0; far_wen = 1'b1;
        @(negedge clk);
        check("R4", sel_a, 2'b10);
        check("R9", sel_b, 2'b00);

        // Exhaustive sweep: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int nd = 0; nd < NR; nd++)
            for (int fd = 0; fd < NR; fd++)
                for (int sa = 0; sa < NR; sa++)
                    for (int sb = 0; sb < NR; sb++)
                        for (int fl = 0; fl < 8; fl++) begin
                            int nw, nl, fw;
                            nw = fl & 1; nl = (fl >> 1) & 1; fw = (fl >> 2) & 1;
                            src_a = AW'(sa); src_b = AW'(sb);
                            near_dst = AW'(nd); far_dst = AW'(fd);
                            near_wen = nw[0]; near_load = nl[0]; far_wen = fw[0];
                            @(negedge clk);
                            check(tag(sa, nd, nw, nl, fd, fw), sel_a, model(sa, nd, nw, nl, fd, fw));
                            check(tag(sb, nd, nw, nl, fd, fw), sel_b, model(sb, nd, nw, nl, fd, fw));
                        end

        // R1: reset asserted mid-run clears both selects
        src_a = 3'd1; near_dst = 3'd1; near_wen = 1'b1; near_load = 1'b0;
        @(negedge clk);
        check("R2", sel_a, 2'b10);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", sel_a, 2'b00);
        check("R1", sel_b, 2'b00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule